// File: doc/BRIEF.md
# Three-Phase Sine Reference Generator

This block produces three balanced sinusoidal modulation references for a carrier-based PWM and converts each one into a compare word for that carrier. The angle is held in an unsigned fixed-point phase accumulator, and one full electrical cycle equals the accumulator's natural overflow. On every sample strobe the accumulator advances by a phase increment plus a phase offset. The increment is the fundamental frequency times the sample interval, expressed in accumulator units. For example, a 100 µs sample interval at 60 Hz gives round(2^32 · 60 · 1e-4).

Three angles are taken from the accumulator, spaced one third of a cycle apart. Each angle selects a sine value from a quarter-wave table, using symmetry to cover all four quadrants. The sine value is scaled by a modulation index in the range 0 to 1. The bipolar result x is then mapped to a compare word equal to period·(x+1)/2. All three words change on the same clock edge, and a one-cycle valid pulse marks that edge, so the PWM shadow registers that follow can take the whole set at once. Closed-loop control and measurement processing are not part of this block.

Top module: `sine3_ref_gen`

## Requirements
- R1: On a clock edge where `strobe_i` is high, the accumulator becomes (accumulator + `phase_inc_i` + `phase_off_i`) mod 2^32. Without a strobe the accumulator keeps its value, and with stable inputs the compare words stay unchanged.
- R2: Wrapping above one cycle or below zero happens through modular arithmetic. A negative offset is written in two's complement and moves the angle backwards across zero.
- R3: The phase A angle is θ. The phase B angle is θ − 1431655765 (mod 2^32) and the phase C angle is θ + 1431655765 (mod 2^32), which is one third of a cycle.
- R4: The sine index p is the top 10 bits of a lane's angle. The lane amplitude is 32767·sin(2π·p/1024), rounded to the nearest integer, and is correct in all four quadrants.
- R5: The modulation index `mod_idx_i` uses 32768 to mean 1.0. Values above 32768 act as 32768. The scaled sample is s = floor(amplitude·m/32768).
- R6: Each compare word is floor(`period_i`·(s+32768)/65536), so it never exceeds `period_i`.
- R7: `valid_o` goes high for exactly one cycle, on the third rising edge counted from the edge that samples the strobe (that edge included). All three compare words take their new values on that same edge.
- R8: Reset clears the accumulator and `valid_o`. Within three clocks after reset is released, and with no strobe applied, the compare words show θ = 0: A is `period_i`/2, and B and C follow sin(∓120°).
- R9: A modulation index of 0 drives all three compare words to floor(`period_i`/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe; advances the angle once per high cycle |
| phase_inc_i | input | 32 | Angle step per sample, 2^32 = one cycle |
| phase_off_i | input | 32 | Extra angle added on each sample, two's complement |
| mod_idx_i | input | 16 | Modulation index, 32768 = 1.0 |
| period_i | input | 16 | Carrier period in counts |
| cmp_a_o | output | 16 | Phase A compare word |
| cmp_b_o | output | 16 | Phase B compare word |
| cmp_c_o | output | 16 | Phase C compare word |
| valid_o | output | 1 | One-cycle pulse when a new set is ready |

## Verification
A corrupted accumulator shows up three clocks after the next strobe, as compare words that match no angle the bench has tracked. Because the angle is cumulative, the error persists on every later sample. A wrong quadrant fold or a wrong lane spacing moves the words by a large fraction of the period in the affected quadrant or lane. A slip in the valid pipeline is seen on the very pulse it affects. Random steps, modulation indices and periods are mixed with directed quarter-cycle steps, wraps across zero, saturating and zero indices, and a reset check.

// File: rtl/sine3_pkg.sv
package sine3_pkg;

   // number of output phases and strobe-to-valid latency
   localparam int NPH = 3;
   localparam int LAT = 3;

   // pi in Q30
   localparam longint PI_Q30 = 64'sd3373259426;

   // magnitude of sin(k*pi/(2n)) scaled to amp_max, rounded; integer series
   function automatic longint quarter_sine(input int k, input int n, input int amp_max);
      longint x;
      longint term;
      longint acc;
      longint res;
      x    = (longint'(k) * PI_Q30) / (longint'(2) * longint'(n));
      term = x;
      acc  = x;
      for (int i = 1; i <= 7; i++) begin
         term = (term * x) >>> 30;
         term = (term * x) >>> 30;
         term = -term / longint'((2 * i) * (2 * i + 1));
         acc  = acc + term;
      end
      res = (acc * longint'(amp_max) + (longint'(1) <<< 29)) >>> 30;
      if (res > longint'(amp_max)) res = longint'(amp_max);
      if (res < 0) res = 0;
      return res;
   endfunction

endpackage

// File: rtl/sine3_phase_acc.sv
module sine3_phase_acc #(
   parameter int PHASE_W = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               step_i,
   input  logic [PHASE_W-1:0] inc_i,
   input  logic [PHASE_W-1:0] off_i,
   output logic [PHASE_W-1:0] phase_o
);

   logic [PHASE_W-1:0] acc_q;
   logic [PHASE_W-1:0] acc_d;

   // modular sum: one cycle is the natural overflow
   assign acc_d = acc_q + inc_i + off_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (step_i) begin
         acc_q <= acc_d;
      end
   end

   assign phase_o = acc_q;

endmodule

// File: rtl/sine3_qlut.sv
module sine3_qlut #(
   parameter int ADDR_W = 8,
   parameter int AMP_W  = 16
) (
   input  logic [ADDR_W+1:0]       idx_i,
   output logic signed [AMP_W-1:0] amp_o
);

   localparam int N       = 1 << ADDR_W;
   localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

   // quarter wave, N+1 points so both ends of the quadrant are exact
   logic [AMP_W-2:0] rom [0:N];

   for (genvar k = 0; k <= N; k++) begin : g_rom
      localparam longint VAL = sine3_pkg::quarter_sine(k, N, AMP_MAX);
      assign rom[k] = VAL[AMP_W-2:0];
   end

   logic [1:0]        quad;
   logic [ADDR_W-1:0] ofs;
   logic [ADDR_W:0]   fwd_a;
   logic [ADDR_W:0]   rev_a;
   logic [ADDR_W:0]   sel_a;
   logic [AMP_W-2:0]  mag;
   logic signed [AMP_W-1:0] mag_s;

   assign quad  = idx_i[ADDR_W+1:ADDR_W];
   assign ofs   = idx_i[ADDR_W-1:0];
   assign fwd_a = {1'b0, ofs};
   assign rev_a = (ADDR_W+1)'(N) - fwd_a;

   // odd quadrants run the table backwards, the lower half-cycle negates
   always_comb begin
      sel_a = quad[0] ? rev_a : fwd_a;
      mag   = rom[sel_a];
      mag_s = $signed({1'b0, mag});
      amp_o = quad[1] ? -mag_s : mag_s;
   end

endmodule

// File: rtl/sine3_lane.sv
module sine3_lane #(
   parameter int ADDR_W = 8,
   parameter int AMP_W  = 16,
   parameter int MOD_W  = 16,
   parameter int PER_W  = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W+1:0] idx_i,
   input  logic [MOD_W-1:0]  mod_i,
   input  logic [PER_W-1:0]  period_i,
   output logic [PER_W-1:0]  cmp_o
);

   localparam logic [MOD_W-1:0] MOD_ONE = MOD_W'(1) << (MOD_W - 1);
   localparam int PROD_W = AMP_W + MOD_W + 1;
   localparam int DUTY_W = AMP_W + PER_W;

   logic signed [AMP_W-1:0]  amp;
   logic [MOD_W-1:0]         m_eff;
   logic signed [MOD_W:0]    m_s;
   logic signed [PROD_W-1:0] prod;
   logic signed [AMP_W-1:0]  samp_d;
   logic signed [AMP_W-1:0]  samp_q;
   logic [AMP_W-1:0]         ubias;
   logic [DUTY_W-1:0]        duty_w;

   sine3_qlut #(
      .ADDR_W (ADDR_W),
      .AMP_W  (AMP_W)
   ) u_lut (
      .idx_i  (idx_i),
      .amp_o  (amp)
   );

   // saturate the index at unity, then scale (floor shift)
   assign m_eff  = (mod_i > MOD_ONE) ? MOD_ONE : mod_i;
   assign m_s    = $signed({1'b0, m_eff});
   assign prod   = amp * m_s;
   assign samp_d = prod[AMP_W+MOD_W-2:MOD_W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         samp_q <= '0;
      end else begin
         samp_q <= samp_d;
      end
   end

   // x+1 as offset binary: flipping the sign bit adds half scale
   assign ubias  = {~samp_q[AMP_W-1], samp_q[AMP_W-2:0]};
   assign duty_w = {{AMP_W{1'b0}}, period_i} * {{PER_W{1'b0}}, ubias};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_o <= '0;
      end else begin
         cmp_o <= duty_w[DUTY_W-1:AMP_W];
      end
   end

   logic unused_bits;
   assign unused_bits = ^{prod[PROD_W-1:AMP_W+MOD_W-1], prod[MOD_W-2:0],
                          duty_w[AMP_W-1:0]};

endmodule

// File: rtl/sine3_ref_gen.sv
module sine3_ref_gen #(
   parameter int PHASE_W = 32,
   parameter int LUT_AW  = 8,
   parameter int AMP_W   = 16,
   parameter int MOD_W   = 16,
   parameter int PER_W   = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               strobe_i,
   input  logic [PHASE_W-1:0] phase_inc_i,
   input  logic [PHASE_W-1:0] phase_off_i,
   input  logic [MOD_W-1:0]   mod_idx_i,
   input  logic [PER_W-1:0]   period_i,
   output logic [PER_W-1:0]   cmp_a_o,
   output logic [PER_W-1:0]   cmp_b_o,
   output logic [PER_W-1:0]   cmp_c_o,
   output logic               valid_o
);

   import sine3_pkg::*;

   localparam int IDX_W = LUT_AW + 2;
   localparam logic [PHASE_W-1:0] THIRD =
      PHASE_W'(((64'd1 << PHASE_W) + 64'd1) / 64'd3);

   // elaboration-time parameter checks
   if (PHASE_W < IDX_W || PHASE_W > 62) begin : g_chk_phase
      $error("PHASE_W must lie between LUT_AW+2 and 62");
   end
   if (LUT_AW < 2 || LUT_AW > 12) begin : g_chk_lut
      $error("LUT_AW must lie between 2 and 12");
   end
   if (AMP_W < 4 || AMP_W > 24) begin : g_chk_amp
      $error("AMP_W must lie between 4 and 24");
   end
   if (MOD_W < 2 || MOD_W > 24) begin : g_chk_mod
      $error("MOD_W must lie between 2 and 24");
   end

   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] ang [NPH];
   logic [PER_W-1:0]   cmp_w [NPH];
   logic [LAT-1:0]     vld_sr;

   sine3_phase_acc #(
      .PHASE_W (PHASE_W)
   ) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (strobe_i),
      .inc_i   (phase_inc_i),
      .off_i   (phase_off_i),
      .phase_o (phase_q)
   );

   for (genvar ph = 0; ph < NPH; ph++) begin : g_lane
      if (ph == 0) begin : g_ang_a
         assign ang[ph] = phase_q;
      end else if (ph == 1) begin : g_ang_b
         assign ang[ph] = phase_q - THIRD;
      end else begin : g_ang_c
         assign ang[ph] = phase_q + THIRD;
      end

      sine3_lane #(
         .ADDR_W   (LUT_AW),
         .AMP_W    (AMP_W),
         .MOD_W    (MOD_W),
         .PER_W    (PER_W)
      ) u_lane (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .idx_i    (ang[ph][PHASE_W-1 -: IDX_W]),
         .mod_i    (mod_idx_i),
         .period_i (period_i),
         .cmp_o    (cmp_w[ph])
      );
   end

   // strobe travels alongside the data through accumulator, scale, duty
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_sr <= '0;
      end else begin
         vld_sr <= {vld_sr[LAT-2:0], strobe_i};
      end
   end

   assign cmp_a_o = cmp_w[0];
   assign cmp_b_o = cmp_w[1];
   assign cmp_c_o = cmp_w[2];
   assign valid_o = vld_sr[LAT-1];

endmodule

// File: rtl/sine3_ref_gen_chk.sv
module sine3_ref_gen_chk #(
   parameter int PHASE_W = 32,
   parameter int MOD_W   = 16,
   parameter int PER_W   = 16
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               strobe_i,
   input logic [PHASE_W-1:0] phase_inc_i,
   input logic [PHASE_W-1:0] phase_off_i,
   input logic [MOD_W-1:0]   mod_idx_i,
   input logic [PER_W-1:0]   period_i,
   input logic [PHASE_W-1:0] phase_i,
   input logic [PER_W-1:0]   cmp_a_i,
   input logic [PER_W-1:0]   cmp_b_i,
   input logic [PER_W-1:0]   cmp_c_i,
   input logic               valid_i
);

   // clocks since reset release, saturating
   logic [1:0] age;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i |=> phase_i == $past(phase_i) + $past(phase_inc_i) + $past(phase_off_i)); // R1

   AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strobe_i |=> $stable(phase_i)); // R1

   AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> $past(strobe_i, 3)); // R7

   AST_DUTY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age == 2'd3) |-> (cmp_a_i <= $past(period_i) && cmp_b_i <= $past(period_i)
                         && cmp_c_i <= $past(period_i))); // R6

   AST_ZERO_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age == 2'd3 && $past(mod_idx_i, 2) == '0) |->
         (cmp_a_i == ($past(period_i) >> 1) && cmp_b_i == ($past(period_i) >> 1)
          && cmp_c_i == ($past(period_i) >> 1))); // R9

endmodule

bind sine3_ref_gen sine3_ref_gen_chk #(
   .PHASE_W (PHASE_W),
   .MOD_W   (MOD_W),
   .PER_W   (PER_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .strobe_i    (strobe_i),
   .phase_inc_i (phase_inc_i),
   .phase_off_i (phase_off_i),
   .mod_idx_i   (mod_idx_i),
   .period_i    (period_i),
   .phase_i     (phase_q),
   .cmp_a_i     (cmp_a_o),
   .cmp_b_i     (cmp_b_o),
   .cmp_c_i     (cmp_c_o),
   .valid_i     (valid_o)
);

// File: tb/sine3_ref_gen_tb.sv
`timescale 1ns/1ps
module sine3_ref_gen_tb;

   localparam logic [31:0] THIRD = 32'd1431655765;
   localparam real TWO_PI = 6.283185307179586;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0;
   logic [31:0] inc = '0;
   logic [31:0] off = '0;
   logic [15:0] mod = 16'd32768;
   logic [15:0] per = 16'd1000;
   logic [15:0] ca, cb, cc;
   logic        vld;

   int tests = 0;
   int fails = 0;
   logic [31:0] theta = '0;

   always #2.5 clk = ~clk;

   sine3_ref_gen u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .strobe_i    (stb),
      .phase_inc_i (inc),
      .phase_off_i (off),
      .mod_idx_i   (mod),
      .period_i    (per),
      .cmp_a_o     (ca),
      .cmp_b_o     (cb),
      .cmp_c_o     (cc),
      .valid_o     (vld)
   );

   function automatic longint exp_amp(input logic [31:0] th);
      real r;
      int  p;
      p = int'(th[31:22]);
      r = 32767.0 * $sin(TWO_PI * real'(p) / 1024.0);
      if (r >= 0.0) return longint'($rtoi(r + 0.5));
      else return -longint'($rtoi(-r + 0.5));
   endfunction

   function automatic int exp_cmp(input logic [31:0] th, input logic [15:0] m,
                                  input logic [15:0] pr);
      longint mm, s, u;
      mm = (m > 16'd32768) ? 32768 : longint'(m);
      s  = (exp_amp(th) * mm) >>> 15;
      u  = s + 32768;
      return int'((longint'(pr) * u) >>> 16);
   endfunction

   task automatic chk(input string tag, input int act, input int exp, input int tol);
      int d;
      tests++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_set(input string tag);
      chk({tag, " phase A"}, int'(ca), exp_cmp(theta, mod, per), 1);
      chk({tag, " phase B"}, int'(cb), exp_cmp(theta - THIRD, mod, per), 1);
      chk({tag, " phase C"}, int'(cc), exp_cmp(theta + THIRD, mod, per), 1);
   endtask

   // one strobe; sample after the third edge, then check the pulse ends
   task automatic step(input logic [31:0] i, input logic [31:0] o,
                       input logic [15:0] m, input logic [15:0] pr, input string tag);
      @(negedge clk);
      inc = i; off = o; mod = m; per = pr; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      theta = theta + i + o;
      chk({tag, " R7 valid early"}, int'(vld), 0, 0);
      @(negedge clk);
      chk({tag, " R7 valid early"}, int'(vld), 0, 0);
      @(negedge clk);
      chk({tag, " R7 valid pulse"}, int'(vld), 1, 0);
      chk_set(tag);
      @(negedge clk);
      chk({tag, " R7 valid one cycle"}, int'(vld), 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] ha, hb, hc;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 valid after reset", int'(vld), 0, 0);
      chk("R8 phase A at zero angle", int'(ca), 500, 0);
      chk_set("R8 reset set");

      // R4: quarter-cycle steps through every quadrant
      for (int q = 0; q < 8; q++) step(32'h4000_0000, 32'd0, 16'd32768, 16'd65535, "R4 R3 quadrant");
      step(32'h1234_5678, 32'd0, 16'd32768, 16'd60000, "R4 R3 off-axis");

      // R2: forward wrap, then a negative offset crossing zero
      theta = theta; // tracked by model
      step(32'hF000_0000, 32'h0800_0000, 16'd30000, 16'd4000, "R2 forward wrap");
      step(32'd0, 32'hC000_0000, 16'd30000, 16'd4000, "R2 offset");
      step(32'd100, 32'h8000_0000, 16'd30000, 16'd4000, "R2 negative wrap");

      // R5: index above unity saturates, R9 zero index
      step(32'h0AAA_0000, 32'd0, 16'hFFFF, 16'd8000, "R5 saturated index");
      step(32'h0AAA_0000, 32'd0, 16'd40000, 16'd8000, "R5 saturated index");
      step(32'h0555_0000, 32'd0, 16'd16384, 16'd8000, "R5 half index");
      step(32'h2100_0000, 32'd0, 16'd0, 16'd777, "R9 zero index");
      chk("R9 exact half period", int'(ca), 388, 0);
      chk("R9 exact half period", int'(cb), 388, 0);
      chk("R9 exact half period", int'(cc), 388, 0);

      // R6: full period and tiny period
      step(32'h0100_0000, 32'd0, 16'd32768, 16'd65535, "R6 max period");
      step(32'h0100_0000, 32'd0, 16'd32768, 16'd1, "R6 unit period");

      // R1: no strobe means no change
      step(32'h0ACE_0000, 32'h0000_1234, 16'd25000, 16'd5000, "R1 base");
      ha = ca; hb = cb; hc = cc;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         inc = $urandom; off = $urandom;
         chk("R1 no strobe valid", int'(vld), 0, 0);
      end
      chk("R1 hold A", int'(ca), int'(ha), 0);
      chk("R1 hold B", int'(cb), int'(hb), 0);
      chk("R1 hold C", int'(cc), int'(hc), 0);

      // random mix (nominal 60 Hz at 100 us is 25769804)
      for (int n = 0; n < 300; n++) begin
         logic [31:0] ri, ro;
         logic [15:0] rm, rp;
         ri = ($urandom % 4 == 0) ? 32'd25769804 : $urandom;
         ro = ($urandom % 3 == 0) ? $urandom : 32'd0;
         rm = 16'($urandom % 40000);
         rp = 16'($urandom);
         step(ri, ro, rm, rp, "R1 R3 R4 R5 R6 random");
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule